// File: doc/BRIEF.md
# Width-Aware Instruction Boundary Decoder

This block sits in front of an instruction sequencer for a 6502-family core that can widen its accumulator and index registers to 16 bits. It takes in a stream of bytes, one at a time, and divides the stream into instructions. For each instruction it reports the opcode, the number of operand bytes that followed it, and the operand assembled into one 16-bit value. An opcode byte keeps the same value in every mode. What changes is the operand length of the immediate loads, which depends on the accumulator and index width flags in force when the opcode arrives. Because of this, the same byte sequence splits at different places depending on the flags.

Three instructions can change the width flags: the flag-clear and flag-set instructions (opcodes C2 and E2) and the emulation exchange (FB). When one of them completes, the decoder stops taking bytes. It waits until the execution side pulses `width_ack`, which confirms that `acc_narrow` and `idx_narrow` now carry the updated widths. Any opcode outside the supported set is flagged as bad and treated as a one-byte instruction.

Top module: `insn_len_decoder`

## Requirements
- R1: After reset, `insn_vld` is 0 and `byte_rdy` is 1.
- R2: Opcode A9 (accumulator immediate load) takes 1 operand byte when `acc_narrow`=1 and 2 operand bytes when `acc_narrow`=0.
- R3: Opcodes A2 and A0 (index immediate loads) take 1 operand byte when `idx_narrow`=1 and 2 when `idx_narrow`=0. `acc_narrow` does not affect them.
- R4: Opcodes 20 (subroutine call), BD (indexed load) and 9D (indexed store) always take 2 operand bytes, whatever the flags are.
- R5: The first operand byte is the low byte: `insn_arg` = {second, first}. A 1-byte operand is zero-extended, and an instruction with no operand reports `insn_arg`=0.
- R6: Opcodes EA, 58, 18, 38, EB and FB take no operand bytes (`insn_nops`=0). Opcodes C2 and E2 always take exactly 1 operand byte.
- R7: The widths are sampled in the cycle the opcode byte is accepted. A change of `acc_narrow` or `idx_narrow` while the operand bytes are still arriving does not change that instruction's length.
- R8: Once the last byte of a C2, E2 or FB instruction has been accepted, `byte_rdy` is 0 starting in the next cycle. It returns to 1 in the cycle after a cycle in which `width_ack`=1. A `width_ack` pulse while not stalled has no effect.
- R9: An unsupported opcode is reported with `insn_bad`=1 and `insn_nops`=0. Supported opcodes report `insn_bad`=0.
- R10: A byte is consumed only in a cycle where `byte_vld`=1 and `byte_rdy`=1. `insn_vld` pulses for one cycle, in the cycle after the instruction's final byte is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | A stream byte is offered |
| byte_in | input | 8 | Stream byte |
| byte_rdy | output | 1 | Decoder accepts a byte this cycle |
| acc_narrow | input | 1 | Accumulator width: 1 = 8 bit, 0 = 16 bit |
| idx_narrow | input | 1 | Index width: 1 = 8 bit, 0 = 16 bit |
| width_ack | input | 1 | Pulse confirming updated width flags after a flag change |
| insn_vld | output | 1 | Instruction result valid (one cycle) |
| insn_op | output | 8 | Opcode of the instruction |
| insn_nops | output | 2 | Number of operand bytes (0 to 2) |
| insn_arg | output | 16 | Assembled little-endian operand |
| insn_bad | output | 1 | Opcode is not in the supported set |

## Verification
The bench feeds the same six-byte sequence once with a narrow accumulator and once with a wide one. It expects three instructions in the first case and two in the second; a decoder that ignored the width flag would report the wrong boundaries and mismatch on every item that follows. It switches `acc_narrow` while an operand is still being collected, which catches a decoder that re-reads the flag for each byte and so ends the instruction early. It also holds a byte on the input during the stall after a flag change and checks that this byte produces no instruction. It then pulses `width_ack` while not stalled and checks that `byte_rdy` stays high, which exposes stall logic that drops or inverts the handshake.

// File: rtl/ild_pkg.sv
package ild_pkg;

  localparam int BYTE_W   = 8;
  localparam int MAX_OPND = 2;
  localparam int CNT_W    = $clog2(MAX_OPND + 1);
  localparam int ARG_W    = BYTE_W * MAX_OPND;

  typedef struct packed {
    logic [CNT_W-1:0] nops;
    logic             known;
    logic             flagop;
  } ild_info_t;

  // Operand length and class of one opcode under the current widths.
  function automatic ild_info_t classify_op(input logic [BYTE_W-1:0] op,
                                            input logic acc_n,
                                            input logic idx_n);
    ild_info_t r;
    r.nops   = '0;
    r.known  = 1'b1;
    r.flagop = 1'b0;
    case (op)
      8'hA9:               r.nops = acc_n ? CNT_W'(1) : CNT_W'(2);
      8'hA2, 8'hA0:        r.nops = idx_n ? CNT_W'(1) : CNT_W'(2);
      8'h20, 8'hBD, 8'h9D: r.nops = CNT_W'(2);
      8'hC2, 8'hE2: begin
        r.nops   = CNT_W'(1);
        r.flagop = 1'b1;
      end
      8'hFB:               r.flagop = 1'b1;
      8'hEB, 8'h58, 8'h18, 8'h38, 8'hEA: r.nops = '0;
      default:             r.known = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ild_classify.sv
module ild_classify
  import ild_pkg::*;
(
  input  logic [BYTE_W-1:0] op_byte,
  input  logic              acc_narrow,
  input  logic              idx_narrow,
  output ild_info_t         info
);

  always_comb info = classify_op(op_byte, acc_narrow, idx_narrow);

endmodule

// File: rtl/ild_collect.sv
module ild_collect
  import ild_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [BYTE_W-1:0] byte_in,
  input  ild_info_t         info,
  output logic              insn_done,
  output logic              flag_done,
  output logic              insn_vld,
  output logic [BYTE_W-1:0] insn_op,
  output logic [CNT_W-1:0]  insn_nops,
  output logic [ARG_W-1:0]  insn_arg,
  output logic              insn_bad
);

  logic                           busy;
  logic [CNT_W-1:0]               left, pos, nops_q;
  logic [BYTE_W-1:0]              op_q;
  logic                           bad_q, flag_q;
  logic [MAX_OPND-1:0][BYTE_W-1:0] slot, slot_n;
  logic [ARG_W-1:0]               arg_n;

  logic [BYTE_W-1:0] cur_op;
  logic [CNT_W-1:0]  cur_nops;
  logic              cur_bad, cur_flag;

  always_comb begin
    cur_op   = busy ? op_q   : byte_in;
    cur_nops = busy ? nops_q : info.nops;
    cur_bad  = busy ? bad_q  : !info.known;
    cur_flag = busy ? flag_q : info.flagop;
    insn_done = accept && (busy ? (left == CNT_W'(1)) : (info.nops == '0));
    flag_done = insn_done && cur_flag;
  end

  // Operand byte slots and little-endian assembly, one per operand byte.
  for (genvar i = 0; i < MAX_OPND; i++) begin : g_slot
    assign slot_n[i] = (busy && pos == CNT_W'(i)) ? byte_in : slot[i];
    assign arg_n[i*BYTE_W +: BYTE_W] =
      (CNT_W'(i) < cur_nops) ? slot_n[i] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      left      <= '0;
      pos       <= '0;
      nops_q    <= '0;
      op_q      <= '0;
      bad_q     <= 1'b0;
      flag_q    <= 1'b0;
      slot      <= '0;
      insn_vld  <= 1'b0;
      insn_op   <= '0;
      insn_nops <= '0;
      insn_arg  <= '0;
      insn_bad  <= 1'b0;
    end else begin
      if (accept) begin
        if (!busy) begin
          op_q   <= byte_in;
          bad_q  <= !info.known;
          flag_q <= info.flagop;
          nops_q <= info.nops;
          if (info.nops != '0) begin
            busy <= 1'b1;
            left <= info.nops;
            pos  <= '0;
          end
        end else begin
          for (int k = 0; k < MAX_OPND; k++)
            if (pos == CNT_W'(k)) slot[k] <= byte_in;
          pos  <= pos + CNT_W'(1);
          left <= left - CNT_W'(1);
          if (left == CNT_W'(1)) busy <= 1'b0;
        end
      end
      insn_vld <= insn_done;
      if (insn_done) begin
        insn_op   <= cur_op;
        insn_nops <= cur_nops;
        insn_arg  <= arg_n;
        insn_bad  <= cur_bad;
      end
    end
  end

  AST_ARG_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    insn_vld && insn_nops < CNT_W'(2) |-> insn_arg[ARG_W-1:BYTE_W] == '0); // R5
  AST_NOARG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    insn_vld && insn_nops == '0 |-> insn_arg == '0); // R5
  AST_BAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    insn_vld && insn_bad |-> insn_nops == '0); // R9
  AST_FIXED_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    insn_vld && (insn_op == 8'h20 || insn_op == 8'hBD || insn_op == 8'h9D)
    |-> insn_nops == CNT_W'(2)); // R4
  AST_FLAG_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    insn_vld && (insn_op == 8'hC2 || insn_op == 8'hE2) |-> insn_nops == CNT_W'(1)); // R6
  AST_VLD_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    insn_vld |-> $past(accept)); // R10

endmodule

// File: rtl/ild_gate.sv
module ild_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_done,
  input  logic width_ack,
  output logic byte_rdy
);

  logic waiting;

  always_ff @(posedge clk) begin
    if (!rst_n)         waiting <= 1'b0;
    else if (flag_done) waiting <= 1'b1;
    else if (width_ack) waiting <= 1'b0;
  end

  assign byte_rdy = !waiting;

endmodule

// File: rtl/insn_len_decoder.sv
module insn_len_decoder
  import ild_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              byte_rdy,
  input  logic              acc_narrow,
  input  logic              idx_narrow,
  input  logic              width_ack,
  output logic              insn_vld,
  output logic [BYTE_W-1:0] insn_op,
  output logic [CNT_W-1:0]  insn_nops,
  output logic [ARG_W-1:0]  insn_arg,
  output logic              insn_bad
);

  ild_info_t info;
  logic      accept, insn_done, flag_done;

  assign accept = byte_vld && byte_rdy;

  ild_classify u_cls (
    .op_byte    (byte_in),
    .acc_narrow (acc_narrow),
    .idx_narrow (idx_narrow),
    .info       (info)
  );

  ild_collect u_col (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .byte_in   (byte_in),
    .info      (info),
    .insn_done (insn_done),
    .flag_done (flag_done),
    .insn_vld  (insn_vld),
    .insn_op   (insn_op),
    .insn_nops (insn_nops),
    .insn_arg  (insn_arg),
    .insn_bad  (insn_bad)
  );

  ild_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .flag_done (flag_done),
    .width_ack (width_ack),
    .byte_rdy  (byte_rdy)
  );

  AST_STALL_AFTER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    insn_vld && !insn_bad && (insn_op == 8'hC2 || insn_op == 8'hE2 || insn_op == 8'hFB)
    |-> !byte_rdy); // R8
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_rdy && width_ack |=> byte_rdy); // R8
  AST_NO_DONE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_rdy |=> !insn_vld || $past(byte_rdy)); // R10

endmodule

// File: tb/insn_len_decoder_test.sv
module insn_len_decoder_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_in = '0;
  logic        byte_rdy;
  logic        acc_narrow = 1'b1;
  logic        idx_narrow = 1'b1;
  logic        width_ack = 1'b0;
  logic        insn_vld;
  logic [7:0]  insn_op;
  logic [1:0]  insn_nops;
  logic [15:0] insn_arg;
  logic        insn_bad;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  logic [26:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  insn_len_decoder uut (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
    .byte_rdy(byte_rdy), .acc_narrow(acc_narrow), .idx_narrow(idx_narrow),
    .width_ack(width_ack), .insn_vld(insn_vld), .insn_op(insn_op),
    .insn_nops(insn_nops), .insn_arg(insn_arg), .insn_bad(insn_bad)
  );

  task automatic expect_insn(input logic [7:0] op, input logic [1:0] n,
                             input logic [15:0] arg, input logic bad, input string tag);
    exp_q.push_back({bad, op, n, arg});
    tag_q.push_back(tag);
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    while (!byte_rdy) @(negedge clk);
    byte_vld = 1'b1;
    byte_in  = b;
    @(negedge clk);
    byte_vld = 1'b0;
  endtask

  task automatic check_bit(input logic act, input logic exp, input string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  // Monitor: compare every produced instruction with the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && insn_vld) begin
      compared++;
      if (exp_q.size() == 0) begin
        mismatched++;
        $display("FAIL R10 unexpected instruction: actual op=%h n=%0d arg=%h bad=%b expected none",
                 insn_op, insn_nops, insn_arg, insn_bad);
      end else begin
        logic [26:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({insn_bad, insn_op, insn_nops, insn_arg} !== e) begin
          mismatched++;
          $display("FAIL %s: actual op=%h n=%0d arg=%h bad=%b expected op=%h n=%0d arg=%h bad=%b",
                   t, insn_op, insn_nops, insn_arg, insn_bad,
                   e[25:18], e[17:16], e[15:0], e[26]);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_bit(insn_vld, 1'b0, "R1 insn_vld after reset");
    check_bit(byte_rdy, 1'b1, "R1 byte_rdy after reset");

    // Narrow accumulator: three instructions (R2, R4, R5, R10)
    expect_insn(8'hA9, 2'd1, 16'h0000, 1'b0, "R2 narrow load");
    expect_insn(8'h20, 2'd2, 16'h90A9, 1'b0, "R4 call address");
    expect_insn(8'h58, 2'd0, 16'h0000, 1'b0, "R6 single byte");
    send_byte(8'hA9); send_byte(8'h00); send_byte(8'h20);
    send_byte(8'hA9); send_byte(8'h90); send_byte(8'h58);

    // Wide accumulator: same bytes, two instructions (R2, R5)
    acc_narrow = 1'b0;
    expect_insn(8'hA9, 2'd2, 16'h2000, 1'b0, "R2 wide load first");
    expect_insn(8'hA9, 2'd2, 16'h5890, 1'b0, "R5 wide load second");
    send_byte(8'hA9); send_byte(8'h00); send_byte(8'h20);
    send_byte(8'hA9); send_byte(8'h90); send_byte(8'h58);

    // Index loads follow idx_narrow only (R3)
    expect_insn(8'hA2, 2'd1, 16'h0034, 1'b0, "R3 narrow index X");
    expect_insn(8'hA0, 2'd1, 16'h00FF, 1'b0, "R3 narrow index Y");
    send_byte(8'hA2); send_byte(8'h34);
    send_byte(8'hA0); send_byte(8'hFF);
    idx_narrow = 1'b0;
    acc_narrow = 1'b1;
    expect_insn(8'hA2, 2'd2, 16'h1234, 1'b0, "R3 wide index X");
    expect_insn(8'hA0, 2'd2, 16'hBEEF, 1'b0, "R3 wide index Y");
    send_byte(8'hA2); send_byte(8'h34); send_byte(8'h12);
    send_byte(8'hA0); send_byte(8'hEF); send_byte(8'hBE);

    // Fixed two-byte addresses in any mode (R4)
    idx_narrow = 1'b1;
    expect_insn(8'hBD, 2'd2, 16'h2000, 1'b0, "R4 indexed load");
    expect_insn(8'h9D, 2'd2, 16'h1000, 1'b0, "R4 indexed store");
    send_byte(8'hBD); send_byte(8'h00); send_byte(8'h20);
    send_byte(8'h9D); send_byte(8'h00); send_byte(8'h10);

    // Single-byte instructions (R6)
    expect_insn(8'hEA, 2'd0, 16'h0000, 1'b0, "R6 nop");
    expect_insn(8'h18, 2'd0, 16'h0000, 1'b0, "R6 clear carry");
    expect_insn(8'h38, 2'd0, 16'h0000, 1'b0, "R6 set carry");
    expect_insn(8'hEB, 2'd0, 16'h0000, 1'b0, "R6 swap halves");
    send_byte(8'hEA); send_byte(8'h18); send_byte(8'h38); send_byte(8'hEB);

    // Unsupported opcodes (R9)
    expect_insn(8'h42, 2'd0, 16'h0000, 1'b1, "R9 bad opcode 42");
    expect_insn(8'hFF, 2'd0, 16'h0000, 1'b1, "R9 bad opcode FF");
    expect_insn(8'hEA, 2'd0, 16'h0000, 1'b0, "R9 good after bad");
    send_byte(8'h42); send_byte(8'hFF); send_byte(8'hEA);

    // Width sampled at opcode (R7)
    acc_narrow = 1'b0;
    expect_insn(8'hA9, 2'd2, 16'h0201, 1'b0, "R7 width held mid-operand");
    send_byte(8'hA9);
    acc_narrow = 1'b1;
    send_byte(8'h01); send_byte(8'h02);

    // Flag clear stalls until width_ack (R8, R10)
    expect_insn(8'hC2, 2'd1, 16'h0030, 1'b0, "R6 flag clear operand");
    send_byte(8'hC2); send_byte(8'h30);
    check_bit(byte_rdy, 1'b0, "R8 stall after flag clear");
    byte_vld = 1'b1;
    byte_in  = 8'hEA;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check_bit(byte_rdy, 1'b0, "R8 stall holds");
    end
    byte_vld = 1'b0;
    acc_narrow = 1'b0;
    idx_narrow = 1'b0;
    width_ack  = 1'b1;
    @(negedge clk);
    width_ack  = 1'b0;
    check_bit(byte_rdy, 1'b1, "R8 release after ack");
    expect_insn(8'hA9, 2'd2, 16'h1234, 1'b0, "R8 new width in effect");
    send_byte(8'hA9); send_byte(8'h34); send_byte(8'h12);

    // Exchange instruction also stalls (R8)
    expect_insn(8'hFB, 2'd0, 16'h0000, 1'b0, "R6 exchange single byte");
    send_byte(8'hFB);
    check_bit(byte_rdy, 1'b0, "R8 stall after exchange");
    width_ack = 1'b1;
    @(negedge clk);
    width_ack = 1'b0;
    check_bit(byte_rdy, 1'b1, "R8 release after exchange");

    // Flag set then narrow load (R8, R2)
    expect_insn(8'hE2, 2'd1, 16'h0030, 1'b0, "R6 flag set operand");
    send_byte(8'hE2); send_byte(8'h30);
    check_bit(byte_rdy, 1'b0, "R8 stall after flag set");
    acc_narrow = 1'b1;
    idx_narrow = 1'b1;
    width_ack  = 1'b1;
    @(negedge clk);
    width_ack  = 1'b0;
    expect_insn(8'hA9, 2'd1, 16'h0055, 1'b0, "R2 narrow after flag set");
    send_byte(8'hA9); send_byte(8'h55);

    // Ack while not stalled has no effect (R8)
    width_ack = 1'b1;
    @(negedge clk);
    width_ack = 1'b0;
    check_bit(byte_rdy, 1'b1, "R8 idle ack ignored");
    expect_insn(8'hEA, 2'd0, 16'h0000, 1'b0, "R8 stream continues");
    send_byte(8'hEA);

    repeat (5) @(negedge clk);
    compared++;
    if (exp_q.size() != 0) begin
      mismatched++;
      $display("FAIL R10 missing instructions: actual %0d pending expected 0", exp_q.size());
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule